// File: doc/BRIEF.md
# Illegal Instruction Exception Classifier

This block sits next to an instruction decoder and sorts every decoded instruction into one of four classes: legal, general illegal, slot illegal or trap. The decoder supplies a decode-valid strobe and a set of attribute flags for the instruction. The block keeps one bit of state, which records whether the next valid decode sits in the delay slot of a delayed branch. The same restricted or undefined instruction is therefore classified differently depending on where it sits. While the floating-point unit is in standby, any instruction the decoder marks as FPU-related is handled as undefined code.

The result is registered. One cycle after a decode, the block reports a one-hot exception code together with a valid pulse. A separate path examines the divider's operands when a divide is requested and flags a divide-by-zero or a signed overflow, also one cycle later. Vector fetch, stacking and the divider itself belong to other blocks. A flush input discards the decode in the same cycle and clears the delay-slot state.

Top module: `illc_top`

## Requirements
- R1: A valid decode outside a delay slot with `isUndef` set produces `excValid`=1 and `excCode`=3'b001 (general illegal) in the cycle after the decode edge.
- R2: A valid decode inside a delay slot with `isUndef` set produces `excCode`=3'b010 (slot illegal) instead of 3'b001.
- R3: Inside a delay slot, a decode with any of `isPcWrite`, `isDelayBranch`, `isWide`, `isBankRestore`, `isDivSigned` or `isDivUnsigned` set produces `excCode`=3'b010. The same flags outside a slot raise no exception.
- R4: When `fpuStandby`=1, a decode with `isFpu`=1 is classified as undefined code, giving 3'b001 outside a slot and 3'b010 inside one. When `fpuStandby`=0, `isFpu` alone raises nothing.
- R5: A decode with `isTrap`=1 and no other fault produces `excCode`=3'b100. Priority from highest to lowest is slot illegal, then general illegal, then trap.
- R6: A legal delayed branch decoded outside a slot sets `slotActive` for exactly the next valid decode. The flag is cleared once that decode is taken. A delayed branch that faults, or that sits in a slot, does not set it.
- R7: While `decValid`=0, `excValid` stays 0 in the following cycle and `slotActive` holds its value, whatever the attribute inputs carry.
- R8: `flush`=1 clears `slotActive` at the next edge and discards any decode presented in the same cycle, so no exception is reported for it.
- R9: `excCode` always has at most one bit set. It is non-zero exactly when `excValid`=1, and `excValid` lasts one cycle per faulting decode.
- R10: A divide request whose divisor is zero sets `divZero` in the next cycle, for signed and unsigned divides alike.
- R11: A signed divide request with dividend 0x80000000 and divisor all ones (-1) sets `divOverflow` in the next cycle. Unsigned requests never set it, and it is never set together with `divZero`.
- R12: After reset, `excValid`, `excCode`, `slotActive`, `divZero` and `divOverflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush; clears slot state, drops current decode |
| decValid | input | 1 | Decode-valid strobe |
| isUndef | input | 1 | Instruction is undefined code |
| isFpu | input | 1 | Instruction is FPU or FPU-related |
| fpuStandby | input | 1 | FPU module is in standby |
| isPcWrite | input | 1 | Instruction rewrites the program counter |
| isWide | input | 1 | Instruction is 32 bits long |
| isBankRestore | input | 1 | Register-bank restore instruction |
| isDivSigned | input | 1 | Signed divide instruction |
| isDivUnsigned | input | 1 | Unsigned divide instruction |
| isTrap | input | 1 | Trap instruction |
| isDelayBranch | input | 1 | Delayed-branch instruction |
| divReq | input | 1 | Divider operands valid |
| divSigned | input | 1 | Divide is signed |
| dividend | input | DATA_W | Divider dividend |
| divisor | input | DATA_W | Divider divisor |
| excValid | output | 1 | Exception report pulse |
| excCode | output | 3 | One-hot code: bit0 general, bit1 slot, bit2 trap |
| slotActive | output | 1 | Next valid decode is a delay slot |
| divZero | output | 1 | Divide-by-zero flag |
| divOverflow | output | 1 | Signed divide overflow flag |

## Verification
The hardest states to reach are the ones where the delay-slot bit and the decode stream drift apart. Examples are a slot that has to survive idle cycles with junk on the attribute lines, a flush that lands together with a faulting decode, and a branch inside a slot that must not arm a second slot. The vector table drives back-to-back decodes in which each delayed branch is followed at once by a restricted instruction, one case per restriction. Directed sequences then insert idle gaps and flushes between the branch and its slot instruction, and follow each one with an undefined opcode whose code shows what the slot state was.

// File: rtl/illc_pkg.sv
package illc_pkg;
  localparam int EXC_W = 3;
  localparam int EXC_GEN_BIT  = 0;
  localparam int EXC_SLOT_BIT = 1;
  localparam int EXC_TRAP_BIT = 2;

  typedef struct packed {
    logic undef;
    logic fpu;
    logic pcWrite;
    logic wide;
    logic bankRestore;
    logic divSigned;
    logic divUnsigned;
    logic trap;
    logic delayBranch;
  } decAttr_t;

  typedef struct packed {
    logic take;
    logic genIll;
    logic slotIll;
    logic trap;
  } excStrobe_t;
endpackage

// File: rtl/illc_ctrl.sv
module illc_ctrl
  import illc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  logic       decValid,
  input  logic       fpuStandby,
  input  decAttr_t   attr,
  output excStrobe_t strobe,
  output logic       slotActive
);
  logic slotQ;
  logic take;
  logic treatUndef;
  logic slotRestrict;
  logic armSlot;

  // a decode is consumed only when valid and not flushed
  assign take = decValid & ~flush;

  // FPU opcodes count as undefined code while the FPU is parked
  assign treatUndef = attr.undef | (attr.fpu & fpuStandby);

  // instructions that are forbidden in a delay slot
  assign slotRestrict = attr.pcWrite | attr.delayBranch | attr.wide |
                        attr.bankRestore | attr.divSigned | attr.divUnsigned;

  always_comb begin
    strobe.take    = take;
    strobe.slotIll = take & slotQ & (treatUndef | slotRestrict);
    strobe.genIll  = take & ~slotQ & treatUndef;
    strobe.trap    = take & attr.trap & ~strobe.slotIll & ~strobe.genIll;
  end

  // only a clean delayed branch outside a slot arms the next decode
  assign armSlot = take & ~slotQ & attr.delayBranch & ~treatUndef;

  always_ff @(posedge clk) begin
    if (!rstN)          slotQ <= 1'b0;
    else if (flush)     slotQ <= 1'b0;
    else if (decValid)  slotQ <= armSlot;
  end

  assign slotActive = slotQ;

  // R6: a slot covers one valid decode only
  p_slot_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && slotQ) |=> !slotQ);

  // R7: idle decode cycles keep the slot state
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!decValid && !flush) |=> $stable(slotQ));

  // R8: flush empties the slot
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !slotQ);

  // R4: an FPU opcode in standby never reaches the trap class
  p_fpu_not_trap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (take && attr.fpu && fpuStandby) |-> !strobe.trap);
endmodule

// File: rtl/illc_dpath.sv
module illc_dpath
  import illc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  excStrobe_t        strobe,
  input  logic              divReq,
  input  logic              divSigned,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              excValid,
  output logic [EXC_W-1:0]  excCode,
  output logic              divZero,
  output logic              divOverflow
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MINUS_ONE = {DATA_W{1'b1}};

  logic [EXC_W-1:0] codeNext;
  logic             isZero;
  logic             isOvf;

  always_comb begin
    codeNext = '0;
    codeNext[EXC_GEN_BIT]  = strobe.genIll;
    codeNext[EXC_SLOT_BIT] = strobe.slotIll;
    codeNext[EXC_TRAP_BIT] = strobe.trap;
  end

  assign isZero = (divisor == '0);
  assign isOvf  = divSigned & (dividend == MOST_NEG) & (divisor == MINUS_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excValid    <= 1'b0;
      excCode     <= '0;
      divZero     <= 1'b0;
      divOverflow <= 1'b0;
    end else begin
      excValid    <= |codeNext;
      excCode     <= codeNext;
      divZero     <= divReq & isZero;
      divOverflow <= divReq & isOvf & ~isZero;
    end
  end

  // R9: code is one-hot and agrees with the valid pulse
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(excCode) && (excValid == (excCode != '0)));

  // R7: nothing taken means nothing reported next cycle
  p_no_take_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> !excValid);

  // R10: zero divisor is flagged one cycle later
  p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (divReq && divisor == '0) |=> divZero);

  // R11: overflow never accompanies a zero flag, never for unsigned
  p_ovf_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    divOverflow |-> !divZero);
  p_unsigned_no_ovf_r11: assert property (@(posedge clk) disable iff (!rstN)
    (divReq && !divSigned) |=> !divOverflow);
endmodule

// File: rtl/illc_top.sv
module illc_top
  import illc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              decValid,
  input  logic              isUndef,
  input  logic              isFpu,
  input  logic              fpuStandby,
  input  logic              isPcWrite,
  input  logic              isWide,
  input  logic              isBankRestore,
  input  logic              isDivSigned,
  input  logic              isDivUnsigned,
  input  logic              isTrap,
  input  logic              isDelayBranch,
  input  logic              divReq,
  input  logic              divSigned,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              excValid,
  output logic [2:0]        excCode,
  output logic              slotActive,
  output logic              divZero,
  output logic              divOverflow
);
  decAttr_t   attr;
  excStrobe_t strobe;

  assign attr = '{undef:       isUndef,
                  fpu:         isFpu,
                  pcWrite:     isPcWrite,
                  wide:        isWide,
                  bankRestore: isBankRestore,
                  divSigned:   isDivSigned,
                  divUnsigned: isDivUnsigned,
                  trap:        isTrap,
                  delayBranch: isDelayBranch};

  illc_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .decValid   (decValid),
    .fpuStandby (fpuStandby),
    .attr       (attr),
    .strobe     (strobe),
    .slotActive (slotActive)
  );

  illc_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .divReq      (divReq),
    .divSigned   (divSigned),
    .dividend    (dividend),
    .divisor     (divisor),
    .excValid    (excValid),
    .excCode     (excCode),
    .divZero     (divZero),
    .divOverflow (divOverflow)
  );

  // R2: a slot decode with undefined code reports the slot class
  p_slot_undef_r2: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !flush && slotActive && isUndef) |=> (excCode == 3'b010));

  // R1: undefined code outside a slot reports the general class
  p_gen_undef_r1: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !flush && !slotActive && isUndef) |=> (excCode == 3'b001));
endmodule

// File: tb/tb_illc_top.sv
module tb_illc_top;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN, flush, decValid;
  logic isUndef, isFpu, fpuStandby, isPcWrite, isWide, isBankRestore;
  logic isDivSigned, isDivUnsigned, isTrap, isDelayBranch;
  logic divReq, divSigned;
  logic [DATA_W-1:0] dividend, divisor;
  logic excValid, slotActive, divZero, divOverflow;
  logic [2:0] excCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  illc_top #(.DATA_W(DATA_W)) dut (.*);

  // attribute bits: undef,fpu,stby,pcw,wide,bank,divs,divu,trap,dbr
  localparam logic [9:0] A_NONE = 10'b0000000000;
  localparam logic [9:0] A_UND  = 10'b1000000000;
  localparam logic [9:0] A_FPU  = 10'b0100000000;
  localparam logic [9:0] A_STBY = 10'b0010000000;
  localparam logic [9:0] A_PCW  = 10'b0001000000;
  localparam logic [9:0] A_WIDE = 10'b0000100000;
  localparam logic [9:0] A_BANK = 10'b0000010000;
  localparam logic [9:0] A_DIVS = 10'b0000001000;
  localparam logic [9:0] A_DIVU = 10'b0000000100;
  localparam logic [9:0] A_TRAP = 10'b0000000010;
  localparam logic [9:0] A_DBR  = 10'b0000000001;
  localparam logic [9:0] A_BR   = A_DBR | A_PCW;

  // entry: attributes, expected code, expected slotActive after the decode
  localparam int NVEC = 34;
  localparam logic [13:0] VEC [NVEC] = '{
    {A_NONE,               3'b000, 1'b0},
    {A_UND,                3'b001, 1'b0},
    {A_TRAP,               3'b100, 1'b0},
    {A_UND | A_TRAP,       3'b001, 1'b0},
    {A_FPU,                3'b000, 1'b0},
    {A_FPU | A_STBY,       3'b001, 1'b0},
    {A_PCW,                3'b000, 1'b0},
    {A_WIDE,               3'b000, 1'b0},
    {A_DIVS,               3'b000, 1'b0},
    {A_BR,                 3'b000, 1'b1},
    {A_UND,                3'b010, 1'b0},
    {A_BR,                 3'b000, 1'b1},
    {A_WIDE,               3'b010, 1'b0},
    {A_BR,                 3'b000, 1'b1},
    {A_BANK,               3'b010, 1'b0},
    {A_BR,                 3'b000, 1'b1},
    {A_DIVS,               3'b010, 1'b0},
    {A_BR,                 3'b000, 1'b1},
    {A_DIVU,               3'b010, 1'b0},
    {A_BR,                 3'b000, 1'b1},
    {A_PCW,                3'b010, 1'b0},
    {A_BR,                 3'b000, 1'b1},
    {A_BR,                 3'b010, 1'b0},
    {A_BR,                 3'b000, 1'b1},
    {A_FPU | A_STBY,       3'b010, 1'b0},
    {A_BR,                 3'b000, 1'b1},
    {A_NONE,               3'b000, 1'b0},
    {A_BR,                 3'b000, 1'b1},
    {A_TRAP | A_PCW,       3'b010, 1'b0},
    {A_BR,                 3'b000, 1'b1},
    {A_FPU,                3'b000, 1'b0},
    {A_NONE,               3'b000, 1'b0},
    {A_UND | A_BR,         3'b001, 1'b0},
    {A_NONE,               3'b000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setAttr(input logic [9:0] a);
    {isUndef, isFpu, fpuStandby, isPcWrite, isWide, isBankRestore,
     isDivSigned, isDivUnsigned, isTrap, isDelayBranch} = a;
  endtask

  // drive one decode at a negedge, return at the next negedge
  task automatic decode(input logic [9:0] a, input logic v, input logic f);
    setAttr(a);
    decValid = v;
    flush = f;
    @(negedge clk);
    decValid = 1'b0;
    flush = 1'b0;
    setAttr(A_NONE);
  endtask

  task automatic divide(input logic s, input logic [31:0] dd, input logic [31:0] dv);
    divReq = 1'b1; divSigned = s; dividend = dd; divisor = dv;
    @(negedge clk);
    divReq = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; flush = 1'b0; decValid = 1'b0; setAttr(A_NONE);
    divReq = 1'b0; divSigned = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    // R12: reset state, with a decode attempt held off by reset
    setAttr(A_UND | A_BR); decValid = 1'b1;
    @(negedge clk);
    chk("R12 excValid", excValid, 0);
    chk("R12 excCode", excCode, 0);
    chk("R12 slotActive", slotActive, 0);
    chk("R12 divZero", divZero, 0);
    chk("R12 divOverflow", divOverflow, 0);
    decValid = 1'b0; setAttr(A_NONE);
    rstN = 1'b1;
    @(negedge clk);

    // table: R1 R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      decode(VEC[i][13:4], 1'b1, 1'b0);
      chk($sformatf("R1-R6 vec%0d excCode", i), excCode, VEC[i][3:1]);
      chk($sformatf("R9 vec%0d excValid", i), excValid, |VEC[i][3:1]);
      chk($sformatf("R6 vec%0d slotActive", i), slotActive, VEC[i][0]);
    end

    // R9: the valid pulse lasts one cycle
    decode(A_UND, 1'b1, 1'b0);
    chk("R9 pulse on", excValid, 1);
    @(negedge clk);
    chk("R9 pulse off", excValid, 0);
    chk("R9 code cleared", excCode, 0);

    // R7: idle cycles with junk attributes report nothing and keep the slot
    decode(A_BR, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      decode(A_UND | A_TRAP | A_BR, 1'b0, 1'b0);
      chk("R7 idle no exception", excValid, 0);
      chk("R7 idle slot held", slotActive, 1);
    end
    decode(A_UND, 1'b1, 1'b0);
    chk("R7 slot survived idle", excCode, 3'b010);

    // R8: flush with a faulting decode in the same cycle
    decode(A_BR, 1'b1, 1'b0);
    chk("R8 armed", slotActive, 1);
    decode(A_UND, 1'b1, 1'b1);
    chk("R8 decode dropped", excValid, 0);
    chk("R8 slot cleared", slotActive, 0);
    decode(A_UND, 1'b1, 1'b0);
    chk("R8 next is general", excCode, 3'b001);
    // R8: a flushed branch does not arm a slot
    decode(A_BR, 1'b1, 1'b1);
    chk("R8 flushed branch no slot", slotActive, 0);

    // R10 / R11: divide operand checks
    divide(1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
    chk("R11 signed overflow", divOverflow, 1);
    chk("R11 overflow no zero", divZero, 0);
    divide(1'b0, 32'h8000_0000, 32'hFFFF_FFFF);
    chk("R11 unsigned no overflow", divOverflow, 0);
    divide(1'b1, 32'h8000_0000, 32'h0000_0001);
    chk("R11 divide by one", divOverflow, 0);
    divide(1'b1, 32'h8000_0000, 32'h0);
    chk("R10 signed zero", divZero, 1);
    chk("R11 no overflow with zero", divOverflow, 0);
    divide(1'b0, 32'h1234_5678, 32'h0);
    chk("R10 unsigned zero", divZero, 1);
    divide(1'b0, 32'h1234_5678, 32'h3);
    chk("R10 nonzero divisor", divZero, 0);
    dividend = 32'h8000_0000; divisor = 32'h0; divSigned = 1'b1;
    @(negedge clk);
    chk("R10 no request no flag", divZero, 0);
    chk("R11 no request no flag", divOverflow, 0);

    finishRun();
  end
endmodule